// File: doc/BRIEF.md
# Floating-Point Minimum / Maximum Selector

This block picks one of two single-precision floating-point operands, `fs` and `ft`, under a two-bit operation code. It covers four selections: signed minimum, signed maximum, smaller magnitude and larger magnitude. The chosen operand is passed through bit for bit, so the block never rounds and never builds a new value. NaN detection, the sign order and the magnitude order all work directly on the sign, exponent and fraction fields, with no arithmetic unit.

A parameter places an optional register stage at the output. With `REG_OUT = 1`, each request marked by `in_valid` gives its result and `out_valid` one clock later. When `in_valid` is low, the last result is held. With `REG_OUT = 0`, the selector is purely combinational and `out_valid` mirrors `in_valid`.

The NaN rules come first. When exactly one operand is NaN, the ordinary one wins. When both are NaN, `fs` wins. The magnitude selections settle a tie in magnitude by choosing the larger signed value.

Top module: `fpsel_unit`

## Requirements
- R1: The result is always the exact 32-bit pattern of either `fs` or `ft`.
- R2: If both operands are NaN (exponent field bits [30:23] all ones and fraction bits [22:0] nonzero), the result is `fs`, whatever the operation code.
- R3: If exactly one operand is NaN, the result is the other operand, whatever the operation code. An infinity (fraction zero) is not a NaN.
- R4: Operation code 0 (signed minimum) gives `fs` when `fs` is strictly less than `ft`, and `ft` otherwise. +0 and -0 compare equal, so that pair gives `ft`.
- R5: Operation code 1 (signed maximum) gives `fs` when `fs` is strictly greater than `ft`, and `ft` otherwise.
- R6: Operation code 2 (smaller magnitude) gives the operand with the smaller unsigned value of bits [30:0]. When those bits are equal, it gives the larger signed operand, or `ft` if the two are also equal in signed order.
- R7: Operation code 3 (larger magnitude) gives the operand with the larger unsigned value of bits [30:0]. Ties are settled as in R6.
- R8: With the output register enabled, `out_valid` in each cycle equals `in_valid` of the previous cycle. `result` takes the selection of a request one clock after it. `result` keeps its value in any cycle after `in_valid` was low.
- R9: While reset is asserted, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a request in this cycle |
| op | input | 2 | 0 minimum, 1 maximum, 2 smaller magnitude, 3 larger magnitude |
| fs | input | 32 | First operand (single precision) |
| ft | input | 32 | Second operand (single precision) |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Selected operand bit pattern |

## Verification
Directed pairs cover each NaN case, which tells the NaN rules apart from ordinary ordering. Signed zeros and equal values show which operand wins a tie in the signed selections. Equal magnitudes with opposite signs check the tie rule of the magnitude selections. Mixed-sign and both-negative pairs show whether the sign order is reversed correctly for negative numbers, and infinities against NaNs check the fraction test. Random pairs are drawn partly from a pool of special encodings, partly as sign-flipped or identical copies, and partly at random. Idle cycles with changed inputs show that the held result does not move.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

    typedef enum logic [1:0] {
        SEL_MIN  = 2'd0,
        SEL_MAX  = 2'd1,
        SEL_MINA = 2'd2,
        SEL_MAXA = 2'd3
    } sel_op_e;

endpackage

// File: rtl/fpsel_classify.sv
module fpsel_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int MAG_W = W - 1
) (
    input  logic [W-1:0]     value,
    output logic             is_nan,
    output logic             sign,
    output logic [MAG_W-1:0] mag
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        sign   = value[W-1];
        exp_f  = value[W-2 -: EXP_W];
        man_f  = value[MAN_W-1:0];
        mag    = value[MAG_W-1:0];
        is_nan = (&exp_f) && (|man_f);
    end

endmodule

// File: rtl/fpsel_compare.sv
module fpsel_compare #(
    parameter int MAG_W = 31
) (
    input  logic             sign_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_b,
    output logic             a_lt_b,
    output logic             a_gt_b,
    output logic             mag_lt,
    output logic             mag_gt
);

    logic both_zero;

    always_comb begin
        mag_lt    = mag_a < mag_b;
        mag_gt    = mag_a > mag_b;
        both_zero = (mag_a == '0) && (mag_b == '0);
        if (both_zero) begin
            a_lt_b = 1'b0;
            a_gt_b = 1'b0;
        end else if (sign_a != sign_b) begin
            a_lt_b = sign_a;
            a_gt_b = sign_b;
        end else if (!sign_a) begin
            a_lt_b = mag_lt;
            a_gt_b = mag_gt;
        end else begin
            a_lt_b = mag_gt;
            a_gt_b = mag_lt;
        end
    end

endmodule

// File: rtl/fpsel_pick.sv
module fpsel_pick
    import fpsel_pkg::*;
#(
    parameter int W = 32
) (
    input  sel_op_e      op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         nan_a,
    input  logic         nan_b,
    input  logic         a_lt_b,
    input  logic         a_gt_b,
    input  logic         mag_lt,
    input  logic         mag_gt,
    output logic [W-1:0] pick
);

    logic take_a;

    always_comb begin
        take_a = 1'b0;
        unique case (op)
            SEL_MIN:  take_a = a_lt_b;
            SEL_MAX:  take_a = a_gt_b;
            SEL_MINA: take_a = mag_lt || (!mag_gt && a_gt_b);
            SEL_MAXA: take_a = mag_gt || (!mag_lt && a_gt_b);
            default:  take_a = 1'b0;
        endcase
        if (nan_a && nan_b)
            pick = opa;
        else if (nan_a)
            pick = opb;
        else if (nan_b)
            pick = opa;
        else
            pick = take_a ? opa : opb;
    end

endmodule

// File: rtl/fpsel_unit.sv
module fpsel_unit
    import fpsel_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter bit REG_OUT = 1'b1,
    localparam int W      = 1 + EXP_W + MAN_W,
    localparam int MAG_W  = W - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] fs,
    input  logic [W-1:0] ft,
    output logic         out_valid,
    output logic [W-1:0] result
);

    logic [1:0][W-1:0]     opnd;
    logic [1:0]            nan_v;
    logic [1:0]            sign_v;
    logic [1:0][MAG_W-1:0] mag_v;
    logic                  a_lt_b, a_gt_b, mag_lt, mag_gt;
    logic [W-1:0]          pick_w;
    sel_op_e               op_e;

    assign opnd[0] = fs;
    assign opnd[1] = ft;
    assign op_e    = sel_op_e'(op);

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpsel_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
            .value  (opnd[gi]),
            .is_nan (nan_v[gi]),
            .sign   (sign_v[gi]),
            .mag    (mag_v[gi])
        );
    end

    fpsel_compare #(.MAG_W(MAG_W)) cmp_i (
        .sign_a (sign_v[0]),
        .mag_a  (mag_v[0]),
        .sign_b (sign_v[1]),
        .mag_b  (mag_v[1]),
        .a_lt_b (a_lt_b),
        .a_gt_b (a_gt_b),
        .mag_lt (mag_lt),
        .mag_gt (mag_gt)
    );

    fpsel_pick #(.W(W)) pick_i (
        .op     (op_e),
        .opa    (fs),
        .opb    (ft),
        .nan_a  (nan_v[0]),
        .nan_b  (nan_v[1]),
        .a_lt_b (a_lt_b),
        .a_gt_b (a_gt_b),
        .mag_lt (mag_lt),
        .mag_gt (mag_gt),
        .pick   (pick_w)
    );

    if (REG_OUT) begin : g_reg
        logic         valid_q;
        logic [W-1:0] res_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                res_q   <= '0;
            end else begin
                valid_q <= in_valid;
                if (in_valid)
                    res_q <= pick_w;
            end
        end

        assign out_valid = valid_q;
        assign result    = res_q;

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R8
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(result))); // R8
        AST_IS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (result == $past(fs) || result == $past(ft))); // R1
        AST_BOTH_NAN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && nan_v[0] && nan_v[1]) |=> result == $past(fs)); // R2
        AST_ONE_NAN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && nan_v[0] && !nan_v[1]) |=> result == $past(ft)); // R3
        AST_MINA_SMALLER: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_e == SEL_MINA && !(|nan_v) && mag_lt)
            |=> result == $past(fs)); // R6
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = pick_w;
    end

endmodule

// File: tb/fpsel_unit_tb.sv
`timescale 1ns/1ps
module fpsel_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] fs = '0;
    logic [31:0] ft = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fpsel_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .fs(fs), .ft(ft), .out_valid(out_valid), .result(result)
    );

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    // total-order key with +0/-0 merged
    function automatic logic [31:0] okey(input logic [31:0] x);
        if (x[30:0] == 0) return 32'h8000_0000;
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic logic [31:0] expect_sel(input logic [1:0] o,
                                               input logic [31:0] a,
                                               input logic [31:0] b);
        logic [31:0] ka, kb;
        if (is_nan(a) && is_nan(b)) return a;
        if (is_nan(a)) return b;
        if (is_nan(b)) return a;
        ka = okey(a);
        kb = okey(b);
        case (o)
            2'd0: return (ka < kb) ? a : b;
            2'd1: return (ka > kb) ? a : b;
            2'd2: return (a[30:0] < b[30:0]) ? a :
                         (a[30:0] > b[30:0]) ? b : ((ka > kb) ? a : b);
            default: return (a[30:0] > b[30:0]) ? a :
                            (a[30:0] < b[30:0]) ? b : ((ka > kb) ? a : b);
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] o,
                                     input logic [31:0] a,
                                     input logic [31:0] b);
        if (is_nan(a) && is_nan(b)) return "R2";
        if (is_nan(a) || is_nan(b)) return "R3";
        case (o)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive at negedge, register at posedge, sample at following negedge
    task automatic run(input logic [1:0] o, input logic [31:0] a,
                       input logic [31:0] b);
        logic [31:0] e;
        e = expect_sel(o, a, b);
        in_valid = 1'b1; op = o; fs = a; ft = b;
        @(negedge clk);
        check("R8 valid", {31'd0, out_valid}, 32'd1);
        check(req_of(o, a, b), result, e);
        if (result !== a && result !== b) check("R1", result, e);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] pick_val(input int sel);
        case (sel)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return 32'h7FC0_0000;
            5: return 32'hFF80_0001;
            6: return 32'h0000_0001;
            7: return 32'h3F80_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        check("R9 valid", {31'd0, out_valid}, 32'd0);   // R9
        check("R9 result", result, 32'd0);              // R9
        rst_n = 1'b1;
        @(negedge clk);

        // R2: both NaN -> fs
        run(2'd0, 32'h7FC0_0001, 32'hFFC0_0002);
        run(2'd3, 32'hFF80_0005, 32'h7FC0_0000);
        // R3: one NaN -> other; infinity is not NaN
        run(2'd1, 32'h7FC0_0000, 32'h3F80_0000);
        run(2'd2, 32'hBF80_0000, 32'hFF80_0001);
        run(2'd0, 32'h7F80_0000, 32'h7F80_0001);
        // R4: min; signed zeros equal -> ft
        run(2'd0, 32'h0000_0000, 32'h8000_0000);
        run(2'd0, 32'h8000_0000, 32'h0000_0000);
        run(2'd0, 32'hC000_0000, 32'hBF80_0000);
        run(2'd0, 32'h3F80_0000, 32'hBF80_0000);
        // R5: max
        run(2'd1, 32'hC000_0000, 32'hBF80_0000);
        run(2'd1, 32'h4000_0000, 32'h3F80_0000);
        run(2'd1, 32'h3F80_0000, 32'h3F80_0000);
        // R6: smaller magnitude; tie -> larger signed
        run(2'd2, 32'hBF80_0000, 32'h4000_0000);
        run(2'd2, 32'hBF80_0000, 32'h3F80_0000);
        run(2'd2, 32'h3F80_0000, 32'hBF80_0000);
        // R7: larger magnitude; tie -> larger signed
        run(2'd3, 32'hC000_0000, 32'h3F80_0000);
        run(2'd3, 32'hBF80_0000, 32'h3F80_0000);
        run(2'd3, 32'h0000_0000, 32'h8000_0000);

        // R8: idle cycle with new inputs leaves result and valid
        begin
            logic [31:0] held;
            held = result;
            in_valid = 1'b0; op = 2'd1; fs = 32'h4100_0000; ft = 32'h3F00_0000;
            @(negedge clk);
            check("R8 idle valid", {31'd0, out_valid}, 32'd0);
            check("R8 idle hold", result, held);
        end

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            int mode;
            a = pick_val($urandom_range(0, 15));
            mode = $urandom_range(0, 3);
            if (mode == 0)      b = a ^ 32'h8000_0000;
            else if (mode == 1) b = a;
            else                b = pick_val($urandom_range(0, 15));
            run(2'($urandom_range(0, 3)), a, b);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule